// File: doc/BRIEF.md
# Sequential Stream-Buffer Prefetcher

This unit sits between a cache and its memory port. On each cache miss it looks in a small set of stream buffers before it goes to memory. Each buffer follows one sequential stream of line addresses. The buffer holds the line that is expected next, and that line stays in the buffer and is never written into the cache.

If a miss finds no buffer for its line, the unit fetches the line from memory on demand and returns it to the cache. It also points the least recently used buffer at the next line, and that line is prefetched once the memory port is free. A miss that finds its line already in a buffer gets the line one cycle later, and the buffer moves on to the following line. A miss whose line is still in flight waits for that fetch to return and does not request the line again.

The memory port carries one request at a time. A prefetch is started only when that port is idle and no cache miss is waiting, so a miss that has already arrived is never held up by a new prefetch. All addresses are line addresses.

Top module: `spf_prefetcher`

## Requirements
- R1: During and right after reset, `miss_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0.
- R2: A miss whose line address matches no stream buffer causes a memory request for that exact address. The cycle after `mem_rsp_valid` returns it, the unit presents `resp_valid` with `resp_addr` equal to the miss address and `resp_data` equal to the memory data.
- R3: After a miss on line A that matched no buffer, the unit issues a prefetch request for A+1. That line is not sent to the cache until a later miss asks for it.
- R4: A miss on a line that a buffer already holds is answered in the next cycle (`resp_valid` one cycle after acceptance) with no new memory request for that line. A prefetch request for the following line then comes next.
- R5: A miss on a line whose prefetch is still outstanding causes no second memory request for that line. The line is delivered once the outstanding fetch returns.
- R6: At most one memory request is outstanding. Once `mem_req_valid` is raised, it and `mem_req_addr` stay steady until `mem_req_ready` is 1. No new request appears before the response to the previous one has arrived.
- R7: A prefetch request is raised only from the idle state with no miss presented. After a miss that matched no buffer, the demand fetch is the first request the unit issues.
- R8: A miss that matches no buffer takes over the least recently used buffer. A hit and an allocation both count as uses of a buffer.
- R9: `miss_ready` is 0 from acceptance of a miss until its line is delivered. Each accepted miss yields exactly one single-cycle `resp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache miss presented |
| miss_addr | input | AW | Line address of the miss |
| miss_ready | output | 1 | Unit can accept a miss this cycle |
| resp_valid | output | 1 | Line returned to the cache (one-cycle pulse) |
| resp_addr | output | AW | Line address of the returned line |
| resp_data | output | DW | Returned line data |
| mem_req_valid | output | 1 | Memory fetch request |
| mem_req_addr | output | AW | Line address requested from memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory returns data for the outstanding request |
| mem_rsp_data | input | DW | Data from memory |

## Verification
The assertions assume that memory asserts `mem_rsp_valid` only while a request is outstanding, and then for exactly one cycle. They also assume the cache holds `miss_valid` and `miss_addr` steady until `miss_ready` takes them. The bench memory model enforces both. It raises a response only a bounded random latency after a handshake, and its ready signal toggles at random. The cache side of the bench keeps each miss asserted until acceptance. It never presents a second miss before the first has been answered.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // State of one stream buffer
  typedef enum logic [1:0] {
    E_EMPTY = 2'd0,  // never allocated
    E_WANT  = 2'd1,  // line address known, fetch not yet issued
    E_PEND  = 2'd2,  // fetch outstanding at memory
    E_READY = 2'd3   // line held
  } ent_st_t;

  // Controller state
  typedef enum logic [1:0] {
    C_IDLE      = 2'd0,
    C_DEM_ISSUE = 2'd1,
    C_DEM_WAIT  = 2'd2,
    C_BUF_WAIT  = 2'd3
  } ctl_st_t;

endpackage

// File: rtl/spf_entry.sv
module spf_entry
  import spf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic          issue_i,
  input  logic          fill_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic          consume_i,
  output ent_st_t       st_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  ent_st_t       st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q;
  logic          data_en;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    data_en = 1'b0;
    if (alloc_i) begin
      addr_d = alloc_addr_i;
      st_d   = E_WANT;
    end else if (consume_i) begin
      addr_d = addr_q + AW'(1);
      st_d   = E_WANT;
    end else if (fill_i && st_q == E_PEND) begin
      data_en = 1'b1;
      st_d    = E_READY;
    end else if (issue_i) begin
      st_d = E_PEND;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_EMPTY;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= fill_data_i;
  end

  // A fill that lands on an outstanding fetch makes the line available
  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !alloc_i && !consume_i && st_q == E_PEND) |=> (st_q == E_READY));

  assign st_o   = st_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

endmodule

// File: rtl/spf_lru.sv
module spf_lru #(
  parameter int NBUF = 4,
  parameter int IW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] lru_idx_o
);

  logic [IW-1:0]   rank_q [NBUF];
  logic [IW-1:0]   rank_d [NBUF];
  logic [NBUF-1:0] oldest;

  for (genvar g = 0; g < NBUF; g++) begin : g_rank
    always_comb begin
      rank_d[g] = rank_q[g];
      if (touch_i) begin
        if (IW'(g) == touch_idx_i)                    rank_d[g] = '0;
        else if (rank_q[g] < rank_q[touch_idx_i])     rank_d[g] = rank_q[g] + IW'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rank_q[g] <= IW'(g);
      else        rank_q[g] <= rank_d[g];
    end

    assign oldest[g] = (rank_q[g] == IW'(NBUF - 1));
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (oldest[i]) lru_idx_o = IW'(i);
    end
  end

  // Ranks stay a permutation: exactly one oldest buffer
  p_single_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);

endmodule

// File: rtl/spf_prefetcher.sv
module spf_prefetcher
  import spf_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NBUF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  output logic          miss_ready,
  output logic          resp_valid,
  output logic [AW-1:0] resp_addr,
  output logic [DW-1:0] resp_data,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);

  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1;

  // Buffer entries
  ent_st_t         ent_st   [NBUF];
  logic [AW-1:0]   ent_addr [NBUF];
  logic [DW-1:0]   ent_data [NBUF];
  logic [NBUF-1:0] alloc, issue, fill, consume;
  logic [AW-1:0]   alloc_addr;

  for (genvar g = 0; g < NBUF; g++) begin : g_ent
    spf_entry #(.AW(AW), .DW(DW)) u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc[g]),
      .alloc_addr_i(alloc_addr),
      .issue_i     (issue[g]),
      .fill_i      (fill[g]),
      .fill_data_i (mem_rsp_data),
      .consume_i   (consume[g]),
      .st_o        (ent_st[g]),
      .addr_o      (ent_addr[g]),
      .data_o      (ent_data[g])
    );
  end

  // Replacement order
  logic          touch;
  logic [IW-1:0] touch_idx, lru_idx;

  spf_lru #(.NBUF(NBUF), .IW(IW)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_i    (touch),
    .touch_idx_i(touch_idx),
    .lru_idx_o  (lru_idx)
  );

  // Lookup: lowest matching buffer, lowest buffer wanting a fetch
  logic          hit_any, want_any;
  logic [IW-1:0] hit_idx, want_idx;

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    want_any = 1'b0;
    want_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (ent_st[i] != E_EMPTY && ent_addr[i] == miss_addr) begin
        hit_any = 1'b1;
        hit_idx = IW'(i);
      end
      if (ent_st[i] == E_WANT) begin
        want_any = 1'b1;
        want_idx = IW'(i);
      end
    end
  end

  // Controller and memory-port registers
  ctl_st_t       st_q, st_d;
  logic [IW-1:0] wait_q, wait_d;
  logic [AW-1:0] dem_addr_q, dem_addr_d;
  logic          resp_vld_q, resp_vld_d;
  logic [AW-1:0] resp_addr_q, resp_addr_d;
  logic [DW-1:0] resp_data_q, resp_data_d;
  logic          resp_en;
  logic          req_vld_q, req_vld_d;
  logic [AW-1:0] req_addr_q, req_addr_d;
  logic          out_q, out_d;
  logic          own_dem_q, own_dem_d;
  logic [IW-1:0] own_idx_q, own_idx_d;

  logic          port_free, rsp_fire, rsp_pf, rsp_taken;
  logic [IW-1:0] victim;

  assign port_free = !req_vld_q && !out_q;
  assign rsp_fire  = out_q && mem_rsp_valid;
  assign rsp_pf    = rsp_fire && !own_dem_q;
  assign victim    = hit_any ? hit_idx : lru_idx;
  assign alloc_addr = miss_addr + AW'(1);

  always_comb begin
    st_d        = st_q;
    wait_d      = wait_q;
    dem_addr_d  = dem_addr_q;
    resp_vld_d  = 1'b0;
    resp_addr_d = resp_addr_q;
    resp_data_d = resp_data_q;
    resp_en     = 1'b0;
    req_vld_d   = req_vld_q;
    req_addr_d  = req_addr_q;
    out_d       = out_q;
    own_dem_d   = own_dem_q;
    own_idx_d   = own_idx_q;
    alloc       = '0;
    issue       = '0;
    consume     = '0;
    rsp_taken   = 1'b0;
    touch       = 1'b0;
    touch_idx   = hit_idx;

    if (req_vld_q && mem_req_ready) begin
      req_vld_d = 1'b0;
      out_d     = 1'b1;
    end
    if (rsp_fire) out_d = 1'b0;

    unique case (st_q)
      C_IDLE: begin
        if (miss_valid) begin
          touch = 1'b1;
          if (hit_any && ent_st[hit_idx] == E_READY) begin
            resp_en = 1'b1; resp_vld_d = 1'b1;
            resp_addr_d = miss_addr; resp_data_d = ent_data[hit_idx];
            consume[hit_idx] = 1'b1;
          end else if (hit_any && ent_st[hit_idx] == E_PEND) begin
            if (rsp_pf && own_idx_q == hit_idx) begin
              resp_en = 1'b1; resp_vld_d = 1'b1;
              resp_addr_d = miss_addr; resp_data_d = mem_rsp_data;
              consume[hit_idx] = 1'b1;
              rsp_taken = 1'b1;
            end else begin
              wait_d = hit_idx;
              st_d   = C_BUF_WAIT;
            end
          end else begin
            touch_idx     = victim;
            alloc[victim] = 1'b1;
            dem_addr_d    = miss_addr;
            st_d          = C_DEM_ISSUE;
          end
        end else if (port_free && want_any) begin
          issue[want_idx] = 1'b1;
          req_vld_d  = 1'b1;
          req_addr_d = ent_addr[want_idx];
          own_dem_d  = 1'b0;
          own_idx_d  = want_idx;
        end
      end
      C_DEM_ISSUE: begin
        if (port_free) begin
          req_vld_d  = 1'b1;
          req_addr_d = dem_addr_q;
          own_dem_d  = 1'b1;
          st_d       = C_DEM_WAIT;
        end
      end
      C_DEM_WAIT: begin
        if (rsp_fire && own_dem_q) begin
          resp_en = 1'b1; resp_vld_d = 1'b1;
          resp_addr_d = dem_addr_q; resp_data_d = mem_rsp_data;
          st_d = C_IDLE;
        end
      end
      C_BUF_WAIT: begin
        if (rsp_pf && own_idx_q == wait_q) begin
          resp_en = 1'b1; resp_vld_d = 1'b1;
          resp_addr_d = ent_addr[wait_q]; resp_data_d = mem_rsp_data;
          consume[wait_q] = 1'b1;
          rsp_taken = 1'b1;
          st_d = C_IDLE;
        end
      end
      default: st_d = C_IDLE;
    endcase

    fill = '0;
    if (rsp_pf && !rsp_taken) fill[own_idx_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= C_IDLE;
      wait_q     <= '0;
      dem_addr_q <= '0;
      resp_vld_q <= 1'b0;
      req_vld_q  <= 1'b0;
      req_addr_q <= '0;
      out_q      <= 1'b0;
      own_dem_q  <= 1'b0;
      own_idx_q  <= '0;
    end else begin
      st_q       <= st_d;
      wait_q     <= wait_d;
      dem_addr_q <= dem_addr_d;
      resp_vld_q <= resp_vld_d;
      req_vld_q  <= req_vld_d;
      req_addr_q <= req_addr_d;
      out_q      <= out_d;
      own_dem_q  <= own_dem_d;
      own_idx_q  <= own_idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (resp_en) begin
      resp_addr_q <= resp_addr_d;
      resp_data_q <= resp_data_d;
    end
  end

  assign miss_ready    = (st_q == C_IDLE);
  assign resp_valid    = resp_vld_q;
  assign resp_addr     = resp_addr_q;
  assign resp_data     = resp_data_q;
  assign mem_req_valid = req_vld_q;
  assign mem_req_addr  = req_addr_q;

  // Assertions
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !mem_req_valid);

  p_req_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_held_line_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && hit_any && ent_st[hit_idx] == E_READY)
      |=> (resp_valid && resp_addr == $past(miss_addr)));

  p_pf_when_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_valid) && !own_dem_q) |-> ($past(st_q) == C_IDLE && !$past(miss_valid)));

  p_busy_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && !resp_vld_d) |=> !miss_ready);

endmodule

// File: tb/spf_prefetcher_tb.sv
module spf_prefetcher_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NBUF = 4;
  localparam int LOGN = 4096;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_valid;
  logic [AW-1:0] miss_addr;
  logic          miss_ready;
  logic          resp_valid;
  logic [AW-1:0] resp_addr;
  logic [DW-1:0] resp_data;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_req_ready;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;

  always #2.5 clk = ~clk;  // 200 MHz

  spf_prefetcher #(.AW(AW), .DW(DW), .NBUF(NBUF)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int req_n  = 0;
  int pulses = 0;
  int misses = 0;
  bit done   = 1'b0;
  logic [AW-1:0] req_log [LOGN];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  function automatic int count_req(input logic [AW-1:0] a);
    int n = 0;
    for (int i = 0; i < req_n && i < LOGN; i++) if (req_log[i] == a) n++;
    return n;
  endfunction

  function automatic int first_req(input logic [AW-1:0] a);
    for (int i = 0; i < req_n && i < LOGN; i++) if (req_log[i] == a) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Memory model: random ready, one request at a time, latency 1..4
  initial begin
    int lat = 0;
    bit outst = 1'b0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        outst = 1'b0;
      end
      if (lat > 0) begin
        lat--;
        if (lat == 0) mem_rsp_valid = 1'b1;
      end
      mem_req_ready = ($urandom_range(9) < 7);
      if (rst_n && mem_req_valid && mem_req_ready) begin
        // R6: a new request must not appear while one is outstanding
        check(!outst, "R6 single outstanding", int'(outst), 0);
        req_log[req_n % LOGN] = mem_req_addr;
        req_n++;
        mem_rsp_data = line_of(mem_req_addr);
        lat   = 1 + $urandom_range(3);
        outst = 1'b1;
      end
    end
  end

  // Response pulse monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && resp_valid) pulses++;
  end

  // One miss; returns latency from acceptance to resp (1 = next cycle)
  task automatic do_miss(input logic [AW-1:0] a, output int lat, output bit busy_after);
    int acc;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    while (!miss_ready) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    miss_valid = 1'b0;
    busy_after = !miss_ready;
    misses++;
    while (!resp_valid) @(negedge clk);
    lat = cyc - acc;
    check(resp_addr == a, "R2 resp address", int'(resp_addr), int'(a));
    check(resp_data == line_of(a), "R2 resp data", int'(resp_data), int'(line_of(a)));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int  lat;
    bit  busy;
    int  p0;
    int  ctr [6];
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    miss_valid = 1'b0;
    miss_addr  = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(miss_ready == 1'b1, "R1 miss_ready", int'(miss_ready), 1);
    check(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", int'(mem_req_valid), 0);
    rst_n = 1'b1;
    idle(2);

    // R2/R3/R7/R9: first miss goes to memory, then next line is prefetched
    do_miss(16'h0100, lat, busy);
    check(busy, "R9 miss_ready low while demand pending", int'(busy), 1);
    check(lat > 1, "R2 demand latency", lat, 2);
    check(count_req(16'h0100) == 1, "R2 demand request", count_req(16'h0100), 1);
    p0 = pulses;
    idle(30);
    check(count_req(16'h0101) == 1, "R3 next line prefetched", count_req(16'h0101), 1);
    check(first_req(16'h0100) < first_req(16'h0101), "R7 demand before prefetch",
          first_req(16'h0100), first_req(16'h0101));
    check(pulses == p0, "R3 prefetched line not pushed to cache", pulses, p0);

    // R4: held line answered next cycle, no refetch, following line prefetched
    do_miss(16'h0101, lat, busy);
    check(lat == 1, "R4 hit latency", lat, 1);
    idle(30);
    check(count_req(16'h0101) == 1, "R4 no refetch", count_req(16'h0101), 1);
    check(count_req(16'h0102) == 1, "R4 next prefetch", count_req(16'h0102), 1);

    // R5: miss on a line whose prefetch is in flight
    do_miss(16'h0200, lat, busy);
    while (count_req(16'h0201) == 0) @(negedge clk);
    do_miss(16'h0201, lat, busy);
    idle(30);
    check(count_req(16'h0201) == 1, "R5 in-flight line not reissued", count_req(16'h0201), 1);

    // R8: LRU replacement
    do_miss(16'h0300, lat, busy);
    idle(30);
    do_miss(16'h0400, lat, busy);
    idle(30);
    do_miss(16'h0102, lat, busy);   // touch first stream
    check(lat == 1, "R4 second stream hit", lat, 1);
    idle(30);
    do_miss(16'h0500, lat, busy);   // evicts 0x200 stream
    idle(30);
    do_miss(16'h0202, lat, busy);   // evicted: must go to memory
    check(lat > 1, "R8 evicted stream misses", lat, 2);
    check(count_req(16'h0202) == 2, "R8 evicted line refetched", count_req(16'h0202), 2);
    idle(30);
    do_miss(16'h0401, lat, busy);
    check(lat == 1, "R8 surviving stream hits", lat, 1);
    idle(30);
    do_miss(16'h0103, lat, busy);
    check(lat == 1, "R8 recently used stream hits", lat, 1);
    idle(5);
    check(pulses == misses, "R9 one pulse per miss", pulses, misses);

    // Random phase: mixed sequential streams and scattered misses (R2 data checks)
    for (int s = 0; s < 6; s++) ctr[s] = 0;
    for (int k = 0; k < 300; k++) begin
      int s = $urandom_range(5);
      logic [AW-1:0] a;
      if ($urandom_range(99) < 85) begin
        a = AW'(16'h1000 + s * 16'h0100 + ctr[s]);
        ctr[s]++;
      end else begin
        a = AW'(16'h8000 + $urandom_range(16'h3FFF));
      end
      do_miss(a, lat, busy);
      idle($urandom_range(6));
    end
    idle(10);
    check(pulses == misses, "R9 pulse count after random phase", pulses, misses);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule